// File: doc/BRIEF.md
# Replicated-Bank DRAM Command Scheduler

This block sits on the controller side of a low-latency DRAM with eight independently timed banks. A client presents read and write requests on two valid/ready ports. The block issues at most one command per clock on a registered command output. That output carries an operation code, a bank mask, a row address, write data and a read tag. A per-bank timer tracks when each bank can accept its next command. Commands to different banks may follow each other with no gap.

A configured replication factor of 1, 2 or 4 makes each write land in that many banks within one command. A later read of the same logical address can then go to whichever copy's bank is free. Reads therefore rarely stall on a busy row cycle. The tag travels with the read command so the client can match responses that come back out of order.

A refresh timer periodically marks every bank as owing a refresh. The scheduler fills cycles that carry no client command with multibank refreshes of up to four free banks. Refreshes that have waited too long take precedence over client traffic.

Top module: `rl_repl_sched`

## Requirements
- R1: While rst_n is low, cmd_op is 0, cmd_banks is 0, and rd_ready and wr_ready are low even when both valids are high. After reset all banks are free and no refresh is owed.
- R2: cfg_repl 0, 1 or 2 selects 1, 2 or 4 copies (3 acts as 2), with 3 bank bits. Let g = 3 - cfg_repl. The replica banks of an address are those whose low g bits equal the address's low g bits. cmd_addr for reads and writes is the address shifted right by g.
- R3: A write is granted only when all its replica banks are free. It issues as one command, cmd_op 2, whose cmd_banks has exactly those banks set.
- R4: A read is granted when any of its replica banks is free. It goes to the lowest-numbered free replica, with cmd_op 1 and a single bit in cmd_banks. With no free replica it waits.
- R5: A command to a bank at clock edge t keeps that bank from receiving any command before edge t + cfg_trc. A cfg_trc of 0 behaves as 1.
- R6: Commands to different banks may issue on consecutive cycles with no idle cycle between them.
- R7: A write is never granted in the cycle right after a read was issued.
- R8: When both ports could be granted, the read wins. At most one of rd_ready and wr_ready is high in any cycle.
- R9: Every REF_INTERVAL cycles, every bank becomes owed a refresh. In a cycle with no client grant, a refresh (cmd_op 3) covers up to REF_MAX of the lowest-numbered banks that are owed and free, and clears what it covers.
- R10: Once refresh has been owed continuously for REF_SLACK cycles, any possible refresh takes precedence over reads and writes.
- R11: cmd_tag carries the read tag on reads and is 0 otherwise. cmd_wdata carries the write data on writes and is 0 otherwise.
- R12: Operation codes are 0 for idle, 1 for read, 2 for write and 3 for refresh. A handshake cycle's command appears on the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_repl | input | 2 | Replication setting: 0, 1 or 2 for 1, 2 or 4 copies |
| cfg_trc | input | TRCW | Row-cycle time in clocks |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | AW | Logical read address |
| rd_tag | input | TW | Client tag for the read |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | AW | Logical write address |
| wr_data | input | DW | Write data |
| cmd_op | output | 2 | Issued operation code |
| cmd_banks | output | NB | Bank mask of the issued command |
| cmd_addr | output | AW | Row address of the issued command |
| cmd_wdata | output | DW | Data of an issued write |
| cmd_tag | output | TW | Tag of an issued read |

## Verification
A bank timer that keeps a wrong value shows within a single cycle. It either denies a read or write that should be granted, or it grants one and puts the wrong bank into cmd_banks. It also changes which replica later reads pick, so the error keeps propagating into subsequent commands. A wrong refresh debt or age changes the choice between refresh and client traffic, and this shows on cmd_op no later than REF_INTERVAL plus REF_SLACK cycles after reset. The bench runs its own behavioural model and compares the ready signals and all command fields against it on every cycle.

// File: rtl/rl_sched_pkg.sv
package rl_sched_pkg;
   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_REF = 2'd3
   } cmd_op_e;

   // the reserved setting 3 falls back to four copies
   function automatic logic [1:0] clamp_repl(input logic [1:0] r);
      return (r == 2'd3) ? 2'd2 : r;
   endfunction
endpackage

// File: rtl/rl_bank_timers.sv
module rl_bank_timers #(
   parameter int NB   = 8,
   parameter int TRCW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TRCW-1:0] cfg_trc,
   input  logic [NB-1:0]   issue_mask,
   output logic [NB-1:0]   bank_free
);
   logic [TRCW-1:0] reload;
   assign reload = (cfg_trc == '0) ? '0 : cfg_trc - 1'b1;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [TRCW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (issue_mask[b])  cnt_q <= reload;
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign bank_free[b] = (cnt_q == '0);
   end

   // R5: arbitration never addresses a bank whose timer is still running
   a_r5_no_busy_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_mask & ~bank_free) == '0);
endmodule

// File: rtl/rl_replica_map.sv
module rl_replica_map #(
   parameter int NB = 8,
   parameter int AW = 16
) (
   input  logic [1:0]    repl,
   input  logic [AW-1:0] addr,
   output logic [NB-1:0] rep_mask,
   output logic [AW-1:0] row_addr
);
   localparam int BB = $clog2(NB);

   logic [BB-1:0] lowmask;
   logic [BB-1:0] grp;
   int unsigned   gbits;

   always_comb begin
      gbits    = BB - int'(repl);
      lowmask  = BB'((32'd1 << gbits) - 32'd1);
      grp      = addr[BB-1:0] & lowmask;
      for (int b = 0; b < NB; b++)
         rep_mask[b] = ((BB'(b) & lowmask) == grp);
      row_addr = addr >> gbits;
   end
endmodule

// File: rtl/rl_refresh_ctl.sv
module rl_refresh_ctl #(
   parameter int NB           = 8,
   parameter int REF_INTERVAL = 64,
   parameter int REF_SLACK    = 16,
   parameter int REF_MAX      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] bank_free,
   input  logic          ref_taken,
   output logic [NB-1:0] ref_mask,
   output logic          ref_urgent
);
   localparam int TMW = $clog2(REF_INTERVAL);
   localparam int AGW = $clog2(REF_SLACK + 1);

   logic [TMW-1:0] tmr_q;
   logic [NB-1:0]  pend_q, pend_d;
   logic [AGW-1:0] age_q, age_d;
   logic           tick;

   assign tick = (tmr_q == TMW'(REF_INTERVAL - 1));

   always_comb begin
      int cnt;
      cnt      = 0;
      ref_mask = '0;
      for (int b = 0; b < NB; b++) begin
         if (pend_q[b] && bank_free[b] && cnt < REF_MAX) begin
            ref_mask[b] = 1'b1;
            cnt = cnt + 1;
         end
      end
   end

   always_comb begin
      pend_d = (pend_q & ~(ref_taken ? ref_mask : '0)) | (tick ? {NB{1'b1}} : '0);
      if (pend_d == '0)                    age_d = '0;
      else if (age_q == AGW'(REF_SLACK))   age_d = age_q;
      else                                 age_d = age_q + 1'b1;
   end

   assign ref_urgent = (age_q == AGW'(REF_SLACK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= '0;
         pend_q <= '0;
         age_q  <= '0;
      end else begin
         tmr_q  <= tick ? '0 : tmr_q + 1'b1;
         pend_q <= pend_d;
         age_q  <= age_d;
      end
   end

   // R9: a refresh only ever covers banks that were owed one
   a_r9_ref_owed: assert property (@(posedge clk) disable iff (!rst_n)
      ref_taken |-> (ref_mask != '0) && ((ref_mask & ~pend_q) == '0));
endmodule

// File: rtl/rl_repl_sched.sv
module rl_repl_sched
   import rl_sched_pkg::*;
#(
   parameter int NB           = 8,
   parameter int AW           = 16,
   parameter int DW           = 32,
   parameter int TW           = 4,
   parameter int TRCW         = 4,
   parameter int REF_INTERVAL = 64,
   parameter int REF_SLACK    = 16,
   parameter int REF_MAX      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_repl,
   input  logic [TRCW-1:0] cfg_trc,
   input  logic            rd_valid,
   output logic            rd_ready,
   input  logic [AW-1:0]   rd_addr,
   input  logic [TW-1:0]   rd_tag,
   input  logic            wr_valid,
   output logic            wr_ready,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   output logic [1:0]      cmd_op,
   output logic [NB-1:0]   cmd_banks,
   output logic [AW-1:0]   cmd_addr,
   output logic [DW-1:0]   cmd_wdata,
   output logic [TW-1:0]   cmd_tag
);
   if (NB < 4 || (NB & (NB - 1)) != 0) begin : g_bad_nb
      $error("NB must be a power of two of at least 4");
   end
   if (AW < $clog2(NB)) begin : g_bad_aw
      $error("AW too narrow for bank bits");
   end
   if (REF_MAX < 1 || REF_MAX > 4) begin : g_bad_refmax
      $error("REF_MAX must lie in 1..4");
   end
   if (REF_INTERVAL < 2 || REF_SLACK < 1) begin : g_bad_ref
      $error("refresh timing parameters out of range");
   end

   logic [1:0]    repl_eff;
   logic [NB-1:0] bank_free, issue_mask;
   logic [NB-1:0] rd_rep, wr_rep, rd_pick, ref_mask;
   logic [AW-1:0] rd_row, wr_row;
   logic          rd_ok, wr_all_free, ref_avail, ref_urgent, last_rd_q;
   cmd_op_e       sel;

   assign repl_eff = clamp_repl(cfg_repl);

   rl_replica_map #(.NB(NB), .AW(AW)) u_rd_map (
      .repl(repl_eff), .addr(rd_addr), .rep_mask(rd_rep), .row_addr(rd_row));

   rl_replica_map #(.NB(NB), .AW(AW)) u_wr_map (
      .repl(repl_eff), .addr(wr_addr), .rep_mask(wr_rep), .row_addr(wr_row));

   rl_bank_timers #(.NB(NB), .TRCW(TRCW)) u_timers (
      .clk(clk), .rst_n(rst_n), .cfg_trc(cfg_trc),
      .issue_mask(issue_mask), .bank_free(bank_free));

   rl_refresh_ctl #(.NB(NB), .REF_INTERVAL(REF_INTERVAL),
                    .REF_SLACK(REF_SLACK), .REF_MAX(REF_MAX)) u_refresh (
      .clk(clk), .rst_n(rst_n), .bank_free(bank_free),
      .ref_taken(sel == OP_REF), .ref_mask(ref_mask), .ref_urgent(ref_urgent));

   // earliest free copy; ties go to the lowest bank number
   always_comb begin
      rd_pick = '0;
      rd_ok   = 1'b0;
      for (int b = 0; b < NB; b++) begin
         if (!rd_ok && rd_rep[b] && bank_free[b]) begin
            rd_pick[b] = 1'b1;
            rd_ok      = 1'b1;
         end
      end
   end

   assign wr_all_free = ((wr_rep & ~bank_free) == '0);
   assign ref_avail   = (ref_mask != '0);

   always_comb begin
      sel        = OP_NOP;
      issue_mask = '0;
      if (ref_urgent && ref_avail) begin
         sel        = OP_REF;
         issue_mask = ref_mask;
      end else if (rd_valid && rd_ok) begin
         sel        = OP_RD;
         issue_mask = rd_pick;
      end else if (wr_valid && wr_all_free && !last_rd_q) begin
         sel        = OP_WR;
         issue_mask = wr_rep;
      end else if (ref_avail) begin
         sel        = OP_REF;
         issue_mask = ref_mask;
      end
   end

   assign rd_ready = rst_n && (sel == OP_RD);
   assign wr_ready = rst_n && (sel == OP_WR);

   cmd_op_e cmd_op_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_op_q  <= OP_NOP;
         cmd_banks <= '0;
         cmd_addr  <= '0;
         cmd_wdata <= '0;
         cmd_tag   <= '0;
         last_rd_q <= 1'b0;
      end else begin
         cmd_op_q  <= sel;
         cmd_banks <= issue_mask;
         cmd_addr  <= (sel == OP_RD) ? rd_row : (sel == OP_WR) ? wr_row : '0;
         cmd_wdata <= (sel == OP_WR) ? wr_data : '0;
         cmd_tag   <= (sel == OP_RD) ? rd_tag : '0;
         last_rd_q <= (sel == OP_RD);
      end
   end
   assign cmd_op = cmd_op_q;

   // R7: a read on the outputs is never followed directly by a write
   a_r7_rd_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_q == OP_RD |=> cmd_op_q != OP_WR);
   // R3: a write lands in exactly as many banks as the replication factor
   a_r3_write_copies: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_q == OP_WR |-> $countones(cmd_banks) == (32'd1 << repl_eff));
   // R4: a read addresses a single bank
   a_r4_read_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_q == OP_RD |-> $countones(cmd_banks) == 1);
   // R8: the two client ports are never granted together
   a_r8_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_ready && wr_ready));
   // R9: a refresh covers between one and REF_MAX banks
   a_r9_ref_size: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_q == OP_REF |-> cmd_banks != '0 && $countones(cmd_banks) <= REF_MAX);
   // R10: an overdue refresh that can issue shows up on the next command
   a_r10_urgent_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_urgent && ref_avail) |=> cmd_op_q == OP_REF);
endmodule

// File: tb/rl_repl_sched_test.sv
`timescale 1ns/1ps
module rl_repl_sched_test;
   localparam int NB = 8, AW = 16, DW = 32, TW = 4, TRCW = 4;
   localparam int RI = 64, RS = 16, RM = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n;
   logic [1:0]      cfg_repl;
   logic [TRCW-1:0] cfg_trc;
   logic            rd_valid, rd_ready, wr_valid, wr_ready;
   logic [AW-1:0]   rd_addr, wr_addr, cmd_addr;
   logic [TW-1:0]   rd_tag, cmd_tag;
   logic [DW-1:0]   wr_data, cmd_wdata;
   logic [1:0]      cmd_op;
   logic [NB-1:0]   cmd_banks;

   rl_repl_sched #(.NB(NB), .AW(AW), .DW(DW), .TW(TW), .TRCW(TRCW),
                   .REF_INTERVAL(RI), .REF_SLACK(RS), .REF_MAX(RM)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_repl(cfg_repl), .cfg_trc(cfg_trc),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_op(cmd_op), .cmd_banks(cmd_banks), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag));

   int nvec = 0, nfail = 0;
   bit finished = 0;
   string phase = "";

   // behavioural reference state
   int bcnt[NB];
   logic [NB-1:0] pend;
   int age, rtmr, repl_i, trc_i;
   bit lastrd;
   int e_op;
   logic [NB-1:0] e_banks;
   logic [AW-1:0] e_addr;
   logic [DW-1:0] e_data;
   logic [TW-1:0] e_tag;

   // stimulus state
   bit rd_have, wr_have;
   int pr_rd, pr_wr, seq_mode;
   logic [AW-1:0] seq_addr;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL [%s] %s %s actual=%0h expected=%0h", phase, req, what, act, exp);
      end
   endtask

   task automatic do_reset(input int repl, input int trc);
      @(negedge clk);
      rst_n = 1'b0; cfg_repl = 2'(repl); cfg_trc = TRCW'(trc);
      rd_valid = 1'b1; wr_valid = 1'b1;
      rd_addr = '0; wr_addr = '0; rd_tag = '0; wr_data = '0;
      @(negedge clk);
      #1;
      // R1: reset holds the outputs idle and refuses requests
      chk("R1", "rd_ready", 64'(rd_ready), 64'd0);
      chk("R1", "wr_ready", 64'(wr_ready), 64'd0);
      chk("R1", "cmd_op", 64'(cmd_op), 64'd0);
      chk("R1", "cmd_banks", 64'(cmd_banks), 64'd0);
      @(negedge clk);
      rd_valid = 1'b0; wr_valid = 1'b0; rst_n = 1'b1;
      rd_have = 0; wr_have = 0; seq_addr = '0;
      repl_i = repl; trc_i = (trc == 0) ? 1 : trc;
      foreach (bcnt[b]) bcnt[b] = 0;
      pend = '0; age = 0; rtmr = 0; lastrd = 0;
      e_op = 0; e_banks = '0; e_addr = '0; e_data = '0; e_tag = '0;
   endtask

   // one cycle: decide from current inputs, advance model, compare after the edge
   task automatic step();
      int g, stride, rd_pick, cnt, op;
      bit wr_ok;
      logic [NB-1:0] wmask, refmask, mask;
      bit tick;
      #1;
      g = 3 - repl_i; stride = 1 << g;
      rd_pick = -1; wr_ok = 1; wmask = '0; refmask = '0; cnt = 0;
      for (int b = 0; b < NB; b++) begin
         if ((b % stride) == (int'(rd_addr) % stride) && bcnt[b] == 0 && rd_pick < 0)
            rd_pick = b;
         if ((b % stride) == (int'(wr_addr) % stride)) begin
            wmask[b] = 1'b1;
            if (bcnt[b] != 0) wr_ok = 0;
         end
         if (pend[b] && bcnt[b] == 0 && cnt < RM) begin refmask[b] = 1'b1; cnt++; end
      end
      if (age >= RS && refmask != 0)               op = 3;
      else if (rd_valid && rd_pick >= 0)           op = 1;
      else if (wr_valid && wr_ok && !lastrd)       op = 2;
      else if (refmask != 0)                       op = 3;
      else                                         op = 0;
      chk("R8", "rd_ready", 64'(rd_ready), 64'(op == 1));
      chk("R7", "wr_ready", 64'(wr_ready), 64'(op == 2));
      mask = (op == 1) ? NB'(1) << rd_pick : (op == 2) ? wmask : (op == 3) ? refmask : '0;
      e_op = op; e_banks = mask;
      e_addr = (op == 1) ? rd_addr >> g : (op == 2) ? wr_addr >> g : '0;
      e_data = (op == 2) ? wr_data : '0;
      e_tag  = (op == 1) ? rd_tag : '0;
      for (int b = 0; b < NB; b++)
         if (mask[b]) bcnt[b] = trc_i - 1;
         else if (bcnt[b] > 0) bcnt[b]--;
      tick = (rtmr == RI - 1);
      rtmr = tick ? 0 : rtmr + 1;
      pend = (pend & ~((op == 3) ? refmask : '0)) | (tick ? '1 : '0);
      age  = (pend == 0) ? 0 : ((age < RS) ? age + 1 : age);
      lastrd = (op == 1);
      if (op == 1) rd_have = 0;
      if (op == 2) wr_have = 0;
      @(negedge clk);
      chk(e_op == 0 ? "R5 R12" : e_op == 1 ? "R4 R12" : e_op == 2 ? "R3 R12" : "R9 R12",
          "cmd_op", 64'(cmd_op), 64'(e_op));
      chk("R2", "cmd_banks", 64'(cmd_banks), 64'(e_banks));
      chk("R2", "cmd_addr", 64'(cmd_addr), 64'(e_addr));
      chk("R11", "cmd_wdata", 64'(cmd_wdata), 64'(e_data));
      chk("R11", "cmd_tag", 64'(cmd_tag), 64'(e_tag));
      if (!rd_have && $urandom_range(99) < pr_rd) begin
         rd_have = 1;
         rd_addr = seq_mode ? seq_addr : AW'($urandom);
         seq_addr = seq_addr + 1'b1;
         rd_tag = TW'($urandom);
      end
      if (!wr_have && $urandom_range(99) < pr_wr) begin
         wr_have = 1;
         wr_addr = AW'($urandom);
         wr_data = DW'($urandom);
      end
      rd_valid = rd_have; wr_valid = wr_have;
   endtask

   task automatic run(input string ph, input int repl, input int trc,
                      input int prr, input int prw, input int sm, input int n);
      phase = ph;
      do_reset(repl, trc);
      pr_rd = prr; pr_wr = prw; seq_mode = sm;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      rst_n = 1'b0; cfg_repl = '0; cfg_trc = 4'd4;
      rd_valid = 0; wr_valid = 0; rd_addr = '0; wr_addr = '0; rd_tag = '0; wr_data = '0;
      // R2 R3 R4 R5 R9 R11: mixed traffic across copy counts and row-cycle times
      for (int r = 0; r < 3; r++) begin
         run("R2 mix trc1", r, 1, 40, 40, 0, 400);
         run("R5 mix trc3", r, 3, 40, 40, 0, 400);
         run("R4 mix trc8", r, 8, 40, 40, 0, 400);
      end
      // R6: reads walking over distinct banks issue back to back
      run("R6 seq reads", 0, 8, 100, 0, 1, 200);
      // R7: writes queued behind a stream of reads
      run("R7 rd then wr", 1, 1, 60, 100, 0, 300);
      // R8: both ports always busy, reads take the slot
      run("R8 both busy", 1, 2, 100, 100, 0, 300);
      // R10: saturated reads leave refresh only the overdue path
      run("R10 urgent ref", 2, 1, 100, 0, 0, 400);
      // R5: zero row-cycle setting behaves as one
      run("R5 trc0", 0, 0, 70, 70, 0, 300);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #500000;
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule